// File: doc/BRIEF.md
# Framebuffer Fetch Address Generator

This block walks a frame buffer in memory and issues one read address for each word that the display pipeline needs during the visible part of a frame. The address is held in halfword units. A bank field fixes the upper byte-address bits for the whole frame. A 21-bit base field moves through the buffer.

The timing generator gives two strobes. A frame strobe reloads the walker from the programmed start. A line strobe opens one line of fetches. Within a line, each accepted request moves the address on by one 32-bit word. When the programmed page width has been fetched, the walker adds a programmable skip and waits for the next line strobe. The skip lets a visible window scan a virtual screen that is wider than the display. Fetching stops for the rest of the frame once the address reaches the programmed end.

The start, end, width and skip values are captured at the frame strobe. Software can therefore reprogram them at any time without disturbing the frame in flight.

Top module: `fb_fetch_addr_gen`

## Requirements
- R1: After reset `rd_valid` is low. It stays low, and line strobes are ignored, until the first frame strobe.
- R2: The byte address on `rd_addr` is built from the halfword address and the bank. Bit 31 is 0. Bits 30:22 are the bank. Bits 21:2 are halfword-address bits 20:1. Bits 1:0 are 0, so the address is word aligned. The first request after a frame strobe and a line strobe carries the start base.
- R3: Each accepted request (`rd_valid` and `rd_ready` high at a clock edge) moves the next request's byte address up by 4, that is, by two halfwords.
- R4: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` holds its value.
- R5: Once page-width halfwords of a line have been accepted, `rd_valid` drops. The address advances by the skip count in addition to the normal step. The next line's first request appears in the cycle after the next line strobe.
- R6: A line strobe that arrives while a line is still being fetched has no effect on the address sequence or on the request count of that line.
- R7: When the address after an accepted request is equal to or past the end base, fetching stops at once, even in the middle of a line. Later line strobes produce no request until the next frame strobe.
- R8: Bank, start base, end base, page width and skip are sampled at the frame strobe. Changing them during the frame does not change that frame's addresses or its stopping point.
- R9: A frame strobe has priority over everything else. It aborts any fetch in progress: `rd_valid` is low in the next cycle. The walker restarts from the newly sampled start base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank | input | 9 | Bank field, becomes byte-address bits 30:22 |
| cfg_start_base | input | 21 | First halfword address of the frame |
| cfg_end_base | input | 21 | Halfword address at which fetching stops |
| cfg_page_width | input | 10 | Halfwords fetched per visible line |
| cfg_line_skip | input | 11 | Halfwords skipped after each line (0 = contiguous) |
| frame_start | input | 1 | One-cycle frame strobe from the timing generator |
| line_start | input | 1 | One-cycle line strobe from the timing generator |
| rd_ready | input | 1 | Memory accepts the current request |
| rd_valid | output | 1 | A read request is present |
| rd_addr | output | 32 | Word-aligned byte address of the request |

## Verification
The properties assume the following about the inputs:
- The start base, page width and skip are even.
- The page width is nonzero.
- The walk never carries out of the 21-bit base field, so the bank bits of consecutive requests can be compared directly.

The strobes are taken to be single-cycle pulses. Every directed frame in the bench is sized to meet these conditions: small even widths and skips, and end bases placed well inside one bank. All strobes and `rd_ready` are driven on the falling clock edge, so each handshake is unambiguous at the rising edge.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;

    localparam int HW_W    = 21;
    localparam int BANK_W  = 9;
    localparam int PW_W    = 10;
    localparam int SKIP_W  = 11;
    localparam int ADDR_W  = 32;
    localparam int COL_W   = PW_W + 1;
    localparam logic [HW_W-1:0] WORD_STEP = HW_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_LINE,
        ST_FETCH,
        ST_DONE
    } walk_state_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [HW_W-1:0]   end_base;
        logic [PW_W-1:0]   page_w;
        logic [SKIP_W-1:0] skip;
    } walk_cfg_t;

    function automatic logic [ADDR_W-1:0] make_byte_addr(
        input logic [BANK_W-1:0] bank,
        input logic [HW_W-1:0]   hw
    );
        return {1'b0, bank, hw[HW_W-1:1], 2'b00};
    endfunction

endpackage

// File: rtl/fb_cfg_shadow.sv
module fb_cfg_shadow
    import fb_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [HW_W-1:0]   end_in,
    input  logic [PW_W-1:0]   page_w_in,
    input  logic [SKIP_W-1:0] skip_in,
    output walk_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (capture) begin
            cfg <= '{bank: bank_in, end_base: end_in,
                     page_w: page_w_in, skip: skip_in};
        end
    end

endmodule

// File: rtl/fb_line_tracker.sv
module fb_line_tracker
    import fb_fetch_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [PW_W-1:0] page_w,
    output logic            line_last
);

    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_after;

    assign col_after = col_q + COL_W'(2);
    assign line_last = (col_after >= {1'b0, page_w});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col_q <= '0;
        end else if (step) begin
            col_q <= col_after;
        end
    end

endmodule

// File: rtl/fb_addr_walker.sv
module fb_addr_walker
    import fb_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HW_W-1:0]   load_val,
    input  logic              step,
    input  logic              line_last,
    input  logic [SKIP_W-1:0] skip,
    output logic [HW_W-1:0]   cur,
    output logic [HW_W-1:0]   nxt
);

    logic [HW_W-1:0] extra;

    assign extra = line_last ? HW_W'(skip) : '0;
    assign nxt   = cur + WORD_STEP + extra;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/fb_fetch_addr_gen.sv
module fb_fetch_addr_gen
    import fb_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [HW_W-1:0]   cfg_start_base,
    input  logic [HW_W-1:0]   cfg_end_base,
    input  logic [PW_W-1:0]   cfg_page_width,
    input  logic [SKIP_W-1:0] cfg_line_skip,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);

    walk_state_t     state_q, state_d;
    walk_cfg_t       cfg;
    logic [HW_W-1:0] cur_hw, nxt_hw;
    logic            line_last;
    logic            accept;
    logic            line_open;

    assign accept    = (state_q == ST_FETCH) && rd_ready && !frame_start;
    assign line_open = (state_q == ST_WAIT_LINE) && line_start && !frame_start;

    fb_cfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .capture   (frame_start),
        .bank_in   (cfg_bank),
        .end_in    (cfg_end_base),
        .page_w_in (cfg_page_width),
        .skip_in   (cfg_line_skip),
        .cfg       (cfg)
    );

    fb_line_tracker u_line (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_start || line_open),
        .step      (accept),
        .page_w    (cfg.page_w),
        .line_last (line_last)
    );

    fb_addr_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_start),
        .load_val  (cfg_start_base),
        .step      (accept),
        .line_last (line_last),
        .skip      (cfg.skip),
        .cur       (cur_hw),
        .nxt       (nxt_hw)
    );

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = ST_WAIT_LINE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_LINE: begin
                    if (line_start) begin
                        state_d = (cur_hw >= cfg.end_base) ? ST_DONE : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_ready) begin
                        if (nxt_hw >= cfg.end_base)  state_d = ST_DONE;
                        else if (line_last)          state_d = ST_WAIT_LINE;
                        else                         state_d = ST_FETCH;
                    end
                end
                ST_DONE:      state_d = ST_DONE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid = (state_q == ST_FETCH);
    assign rd_addr  = make_byte_addr(cfg.bank, cur_hw);

endmodule

// File: rtl/fb_fetch_checker.sv
module fb_fetch_checker
    import fb_fetch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);

    assert_word_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && !frame_start) |=>
            (!rd_valid || rd_addr == $past(rd_addr) + ADDR_W'(4)));

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !frame_start) |=> (rd_valid && $stable(rd_addr)));

    assert_bank_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !frame_start) |=>
            (!rd_valid || rd_addr[ADDR_W-2 -: BANK_W] == $past(rd_addr[ADDR_W-2 -: BANK_W])));

    assert_frame_abort_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !rd_valid);

endmodule

bind fb_fetch_addr_gen fb_fetch_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr)
);

// File: tb/fb_fetch_addr_gen_tb.sv
module fb_fetch_addr_gen_tb;
    import fb_fetch_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [BANK_W-1:0] cfg_bank = '0;
    logic [HW_W-1:0]   cfg_start_base = '0;
    logic [HW_W-1:0]   cfg_end_base = '0;
    logic [PW_W-1:0]   cfg_page_width = '0;
    logic [SKIP_W-1:0] cfg_line_skip = '0;
    logic              frame_start = 1'b0;
    logic              line_start = 1'b0;
    logic              rd_ready = 1'b0;
    logic              rd_valid;
    logic [ADDR_W-1:0] rd_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fb_fetch_addr_gen u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_bank       (cfg_bank),
        .cfg_start_base (cfg_start_base),
        .cfg_end_base   (cfg_end_base),
        .cfg_page_width (cfg_page_width),
        .cfg_line_skip  (cfg_line_skip),
        .frame_start    (frame_start),
        .line_start     (line_start),
        .rd_ready       (rd_ready),
        .rd_valid       (rd_valid),
        .rd_addr        (rd_addr)
    );

    function automatic logic [31:0] exp_addr(input logic [8:0] bank, input logic [20:0] hw);
        return {1'b0, bank, hw[20:1], 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic start_frame(input logic [8:0] bank, input logic [20:0] base,
                               input logic [20:0] endb, input logic [9:0] pw,
                               input logic [10:0] skip);
        cfg_bank = bank; cfg_start_base = base; cfg_end_base = endb;
        cfg_page_width = pw; cfg_line_skip = skip;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic line_go();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic expect_line(input string req, input logic [8:0] bank,
                               input logic [20:0] hw0, input int n);
        rd_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk({req, " valid"}, 32'(rd_valid), 32'd1);
            chk({req, " addr"}, rd_addr, exp_addr(bank, hw0 + 21'(2 * i)));
            @(negedge clk);
        end
        chk({req, " line end"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic test_reset();
        chk("R1 reset valid", 32'(rd_valid), 32'd0);
        line_go();
        chk("R1 line strobe before frame", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R1 still idle", 32'(rd_valid), 32'd0);
    endtask

    task automatic test_contiguous();
        start_frame(9'h05A, 21'h100, 21'h118, 10'd8, 11'd0);
        chk("R5 wait for line", 32'(rd_valid), 32'd0);
        line_go();
        expect_line("R2 R3 line0", 9'h05A, 21'h100, 4);
        @(negedge clk);
        chk("R5 idle between lines", 32'(rd_valid), 32'd0);
        line_go();
        expect_line("R3 line1", 9'h05A, 21'h108, 4);
        line_go();
        expect_line("R3 line2", 9'h05A, 21'h110, 4);
        line_go();
        chk("R7 contiguous end", 32'(rd_valid), 32'd0);
    endtask

    task automatic test_skip();
        start_frame(9'h1C3, 21'h100, 21'h124, 10'd8, 11'd4);
        line_go();
        expect_line("R5 skip line0", 9'h1C3, 21'h100, 4);
        line_go();
        expect_line("R5 skip line1", 9'h1C3, 21'h10C, 4);
        line_go();
        expect_line("R5 skip line2", 9'h1C3, 21'h118, 4);
        line_go();
        chk("R7 no fetch after end", 32'(rd_valid), 32'd0);
        line_go();
        chk("R7 still stopped", 32'(rd_valid), 32'd0);
    endtask

    task automatic test_backpressure();
        start_frame(9'h033, 21'h400, 21'h500, 10'd8, 11'd0);
        rd_ready = 1'b0;
        line_go();
        for (int i = 0; i < 3; i++) begin
            chk("R4 valid held", 32'(rd_valid), 32'd1);
            chk("R4 addr held", rd_addr, exp_addr(9'h033, 21'h400));
            @(negedge clk);
        end
        expect_line("R4 after stall", 9'h033, 21'h400, 4);
    endtask

    task automatic test_ignore_line_start();
        start_frame(9'h0F0, 21'h600, 21'h700, 10'd8, 11'd0);
        line_go();
        rd_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            line_start = (i == 1);
            chk("R6 valid", 32'(rd_valid), 32'd1);
            chk("R6 addr", rd_addr, exp_addr(9'h0F0, 21'h600 + 21'(2 * i)));
            @(negedge clk);
        end
        line_start = 1'b0;
        chk("R6 count unchanged", 32'(rd_valid), 32'd0);
        line_go();
        expect_line("R6 next line", 9'h0F0, 21'h608, 4);
    endtask

    task automatic test_midline_stop();
        start_frame(9'h011, 21'h100, 21'h104, 10'd8, 11'd0);
        line_go();
        expect_line("R7 midline stop", 9'h011, 21'h100, 2);
        line_go();
        chk("R7 line strobe after stop", 32'(rd_valid), 32'd0);
    endtask

    task automatic test_shadow();
        start_frame(9'h0AA, 21'h200, 21'h210, 10'd4, 11'd0);
        cfg_bank = 9'h155; cfg_start_base = 21'h040; cfg_end_base = 21'h1000;
        cfg_page_width = 10'd16; cfg_line_skip = 11'd6;
        for (int ln = 0; ln < 4; ln++) begin
            line_go();
            expect_line("R8 shadowed cfg", 9'h0AA, 21'h200 + 21'(4 * ln), 2);
        end
        line_go();
        chk("R8 shadowed end", 32'(rd_valid), 32'd0);
    endtask

    task automatic test_restart();
        start_frame(9'h077, 21'h300, 21'h400, 10'd8, 11'd0);
        line_go();
        rd_ready = 1'b1;
        chk("R9 first fetch", rd_addr, exp_addr(9'h077, 21'h300));
        @(negedge clk);
        chk("R9 second fetch", rd_addr, exp_addr(9'h077, 21'h302));
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk("R9 abort", 32'(rd_valid), 32'd0);
        line_go();
        expect_line("R9 restart", 9'h077, 21'h300, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_contiguous();
        test_skip();
        test_backpressure();
        test_ignore_line_start();
        test_midline_stop();
        test_shadow();
        test_restart();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule